// File: doc/BRIEF.md
# Switched-Capacitor Array Readout Sequencer

This block drives an external waveform sampler built around a circular array of capacitor cells (1024 by default). After reset it shifts three preset bytes into the sampler over a serial configuration port: a control byte whose bit 0 turns on circular sampling, a write-shift byte and a write-configuration byte. In cascade mode, where two channels are chained into one 2048-sample record, the write-shift byte is 8'h55. Otherwise it is 8'hFF. The write-configuration byte is 8'hFF in both cases. The sampler then records continuously with its write enable high.

A trigger ends sampling. The sequencer drops the write enable and latches the cell index where the write stopped. In cascade mode it then reads the status bit that tells which half of the chained pair was written last. Next it issues a single readout-start pulse, which puts the stop cell on the analog output. It waits a programmable settling gap and then clocks out either the whole array or a shorter region of interest. Every shift clock is followed by a convert strobe to an external ADC. Each converted word comes out with its logical index, its physical cell, the stop cell and the half bit, so that downstream logic can apply per-cell corrections.

Top module: `sca_readout_seq`

## Requirements
- R1: After reset the preset port sends 24 bits, most significant bit first, each valid while `cfg_sclk` is high. Bits 0–7 go out with `cfg_sel`=0 and carry the control byte 8'h01 (bit 0 = circular sampling). Bits 8–15 go out with `cfg_sel`=1 and carry the write-shift byte: 8'h55 if `cfg_cascade` was high during reset, otherwise 8'hFF. Bits 16–23 go out with `cfg_sel`=2 and carry the write-configuration byte 8'hFF. `smp_wen` stays low until the transfer ends and then goes high.
- R2: A trigger accepted in cycle T drives `smp_wen` low in cycle T+1 and latches `smp_pos` as the stop cell. Exactly one single-cycle `smp_load` pulse follows, in cycle T+1 without cascade.
- R3: With cascade, cycles T+1 and T+2 drive `smp_addr`=4'b1101 with `smp_wen` low. `smp_srout` is sampled in cycle T+2 and reported as `res_half`. `smp_load` comes in cycle T+3. Without cascade, `res_half` is 0.
- R4: The first `smp_sclk` comes exactly `cfg_settle`+1 cycles after `smp_load`. A setting of 0 makes the two adjacent.
- R5: The readout length N is `cfg_roi_len` when `cfg_roi_en` is high and the length is between 1 and 1024. In every other case N is 1024. N `smp_sclk` pulses are issued, two cycles apart.
- R6: Each `smp_sclk` pulse is followed 2 cycles later by `adc_strobe`. `adc_data` is captured 1 cycle after the strobe, and `res_valid` shows it in the following cycle.
- R7: Results come out in order with `res_idx` = 0..N-1. `res_cell` = (stop + index) mod 1024, and `res_stop` holds the latched stop cell.
- R8: `busy` is high from T+1 up to, but not including, the single `done` cycle. That cycle directly follows the last `res_valid`, and `smp_wen` returns high in the next cycle.
- R9: A trigger while `busy` is high has no effect. No new load pulse is issued, and the stop cell and result count of the running event are kept.
- R10: `mode_err` goes high the cycle after `cfg_segment` is raised. This is a request for back-to-back segmented captures, which is rejected. While `mode_err` is high, triggers are ignored and `smp_wen` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_cascade | input | 1 | Chained two-channel mode, sampled during reset |
| cfg_segment | input | 1 | Segmented-capture request (rejected) |
| cfg_roi_en | input | 1 | Enable region-of-interest length |
| cfg_roi_len | input | 11 | Region-of-interest cell count |
| cfg_settle | input | 8 | Gap cycles between load pulse and first shift clock |
| trig | input | 1 | Trigger |
| smp_pos | input | 10 | Current write cell of the sampler |
| smp_srout | input | 1 | Serial status bit from the sampler |
| adc_data | input | 12 | ADC conversion result |
| smp_wen | output | 1 | Sampler write enable |
| smp_load | output | 1 | Readout-start pulse |
| smp_sclk | output | 1 | Readout shift clock |
| smp_addr | output | 4 | Sampler output multiplexer address |
| cfg_sclk | output | 1 | Preset serial clock |
| cfg_sdata | output | 1 | Preset serial data |
| cfg_sel | output | 2 | Preset register select |
| adc_strobe | output | 1 | ADC convert strobe |
| busy | output | 1 | Readout in progress |
| done | output | 1 | Event finished (one cycle) |
| mode_err | output | 1 | Segmented request rejected |
| res_valid | output | 1 | Result valid |
| res_idx | output | 10 | Logical sample index |
| res_cell | output | 10 | Physical cell index |
| res_data | output | 12 | Converted sample |
| res_stop | output | 10 | Latched stop cell |
| res_half | output | 1 | Last-written half of the cascaded pair |

## Verification
The bench fires a trigger near the top of the array and checks that the physical cell index wraps from 1023 to 0. A design that started readout at cell 0, or that forgot the modulo, would report wrong cells after the wrap. It runs settling gaps of 0, 1 and 10 and region lengths of 1, 128, 0 (which falls back to the full array) and the full array. This catches off-by-one gaps and early or late stops, including a last index that is never reported. It also sends a trigger during readout, which a careless design would answer with a second load pulse or an overwritten stop cell. It raises the segmented request, which a weak design would ignore and then capture anyway. In cascade mode it checks both values of the status bit, which exposes a design that samples the wrong cycle or never drives the status address.

// File: rtl/sca_pkg.sv
package sca_pkg;

    typedef enum logic [2:0] {
        ST_PRESET,
        ST_RUN,
        ST_HALF,
        ST_START,
        ST_SETTLE,
        ST_SHIFT,
        ST_DRAIN,
        ST_DONE
    } seq_state_t;

    localparam logic [3:0] ADDR_WSHIFT = 4'b1101;
    localparam logic [3:0] ADDR_IDLE   = 4'b0000;

    typedef struct packed {
        logic [7:0] ctrl;
        logic [7:0] wshift;
        logic [7:0] wcfg;
    } preset_t;

    localparam int PRESET_BITS = $bits(preset_t);

    function automatic preset_t make_preset(input logic cascade);
        preset_t p;
        p.ctrl   = 8'h01;
        p.wshift = cascade ? 8'h55 : 8'hFF;
        p.wcfg   = 8'hFF;
        return p;
    endfunction

endpackage

// File: rtl/sca_cfg_loader.sv
module sca_cfg_loader
    import sca_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cascade_i,
    output logic       busy_o,
    output logic       casc_o,
    output logic       sclk_o,
    output logic       sdata_o,
    output logic [1:0] sel_o
);
    localparam int BW = $clog2(PRESET_BITS);

    logic [PRESET_BITS-1:0] word_q;
    logic [BW-1:0]          bit_q;
    logic                   ph_q;
    logic                   act_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= make_preset(cascade_i);
            casc_o <= cascade_i;
            bit_q  <= '0;
            ph_q   <= 1'b0;
            act_q  <= 1'b1;
        end else if (act_q) begin
            ph_q <= ~ph_q;
            if (ph_q) begin
                if (bit_q == BW'(PRESET_BITS - 1)) act_q <= 1'b0;
                else                               bit_q <= bit_q + 1'b1;
            end
        end
    end

    always_comb begin
        busy_o  = act_q;
        sclk_o  = act_q & ph_q;
        sdata_o = act_q & word_q[BW'(PRESET_BITS - 1) - bit_q];
        sel_o   = act_q ? 2'(bit_q >> 3) : 2'd0;
    end

    // R1: once the preset transfer ends it never restarts without reset
    a_r1_no_rearm: assert property (@(posedge clk) disable iff (rst)
        !act_q |=> !act_q);

endmodule

// File: rtl/sca_seq_fsm.sv
module sca_seq_fsm
    import sca_pkg::*;
#(
    parameter int CELLS = 1024,
    parameter int SETW  = 8,
    parameter int TOT   = 3,
    localparam int CW   = $clog2(CELLS),
    localparam int LW   = CW + 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            ld_busy_i,
    input  logic            casc_i,
    input  logic            seg_i,
    input  logic            roi_en_i,
    input  logic [LW-1:0]   roi_len_i,
    input  logic [SETW-1:0] settle_i,
    input  logic            trig_i,
    input  logic [CW-1:0]   pos_i,
    input  logic            srout_i,
    output logic            wen_o,
    output logic            load_o,
    output logic            sclk_o,
    output logic [3:0]      addr_o,
    output logic            busy_o,
    output logic            done_o,
    output logic            err_o,
    output logic [CW-1:0]   idx_o,
    output logic [CW-1:0]   stop_o,
    output logic            half_o,
    output logic [LW-1:0]   len_o
);
    localparam int DW   = $clog2(TOT + 1);
    localparam int CNTW = (SETW > DW) ? SETW : DW;

    seq_state_t      state_q;
    logic [CNTW-1:0] cnt_q;
    logic [SETW-1:0] settle_q;
    logic [LW-1:0]   len_q;
    logic [CW-1:0]   idx_q;
    logic [CW-1:0]   stop_q;
    logic            half_q;
    logic            ph_q;
    logic            err_q;
    logic [LW-1:0]   len_n;

    always_comb begin
        if (roi_en_i && roi_len_i != '0 && roi_len_i <= LW'(CELLS)) len_n = roi_len_i;
        else                                                       len_n = LW'(CELLS);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_PRESET;
            cnt_q    <= '0;
            settle_q <= '0;
            len_q    <= LW'(CELLS);
            idx_q    <= '0;
            stop_q   <= '0;
            half_q   <= 1'b0;
            ph_q     <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            err_q <= seg_i;
            unique case (state_q)
                ST_PRESET: if (!ld_busy_i) state_q <= ST_RUN;
                ST_RUN: begin
                    if (trig_i && !err_q) begin
                        stop_q   <= pos_i;
                        settle_q <= settle_i;
                        len_q    <= len_n;
                        half_q   <= 1'b0;
                        cnt_q    <= '0;
                        state_q  <= casc_i ? ST_HALF : ST_START;
                    end
                end
                ST_HALF: begin
                    cnt_q <= cnt_q + 1'b1;
                    if (cnt_q[0]) begin
                        half_q  <= srout_i;
                        state_q <= ST_START;
                    end
                end
                ST_START: begin
                    cnt_q   <= '0;
                    idx_q   <= '0;
                    ph_q    <= 1'b0;
                    state_q <= (settle_q == '0) ? ST_SHIFT : ST_SETTLE;
                end
                ST_SETTLE: begin
                    if (cnt_q == CNTW'(settle_q) - CNTW'(1)) begin
                        cnt_q   <= '0;
                        state_q <= ST_SHIFT;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_SHIFT: begin
                    ph_q <= ~ph_q;
                    if (ph_q) begin
                        if ({1'b0, idx_q} == len_q - LW'(1)) begin
                            cnt_q   <= '0;
                            state_q <= ST_DRAIN;
                        end else begin
                            idx_q <= idx_q + 1'b1;
                        end
                    end
                end
                ST_DRAIN: begin
                    if (cnt_q == CNTW'(TOT - 1)) state_q <= ST_DONE;
                    else                         cnt_q   <= cnt_q + 1'b1;
                end
                ST_DONE: state_q <= ST_RUN;
                default: state_q <= ST_PRESET;
            endcase
        end
    end

    always_comb begin
        wen_o  = (state_q == ST_RUN);
        load_o = (state_q == ST_START);
        sclk_o = (state_q == ST_SHIFT) && !ph_q;
        addr_o = (state_q == ST_HALF) ? ADDR_WSHIFT : ADDR_IDLE;
        busy_o = (state_q == ST_HALF) || (state_q == ST_START) || (state_q == ST_SETTLE)
              || (state_q == ST_SHIFT) || (state_q == ST_DRAIN);
        done_o = (state_q == ST_DONE);
        err_o  = err_q;
        idx_o  = idx_q;
        stop_o = stop_q;
        half_o = half_q;
        len_o  = len_q;
    end

    // checker: cycles counted since the load pulse
    logic [SETW-1:0] gap_q;
    always_ff @(posedge clk) begin
        if (rst)                        gap_q <= '0;
        else if (state_q == ST_START)   gap_q <= '0;
        else if (state_q == ST_SETTLE)  gap_q <= gap_q + 1'b1;
    end

    a_r4_settle_gap: assert property (@(posedge clk) disable iff (rst)
        (sclk_o && idx_q == '0) |-> (gap_q == settle_q));

    a_r2_single_load: assert property (@(posedge clk) disable iff (rst)
        load_o |=> !load_o);

    a_r8_no_write_in_readout: assert property (@(posedge clk) disable iff (rst)
        busy_o |-> !wen_o);

    a_r9_stop_held: assert property (@(posedge clk) disable iff (rst)
        (busy_o && trig_i) |=> $stable(stop_q));

    a_r10_reject_segment: assert property (@(posedge clk) disable iff (rst)
        (err_o && wen_o) |=> wen_o);

endmodule

// File: rtl/sca_adc_pipe.sv
module sca_adc_pipe #(
    parameter int CELLS      = 1024,
    parameter int ADW        = 12,
    parameter int STROBE_LAT = 2,
    parameter int DATA_LAT   = 1,
    localparam int CW        = $clog2(CELLS),
    localparam int LW        = CW + 1,
    localparam int TOT       = STROBE_LAT + DATA_LAT
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           sclk_i,
    input  logic [CW-1:0]  idx_i,
    input  logic [CW-1:0]  stop_i,
    input  logic           half_i,
    input  logic [LW-1:0]  len_i,
    input  logic [ADW-1:0] adc_data_i,
    output logic           strobe_o,
    output logic           res_valid_o,
    output logic [CW-1:0]  res_idx_o,
    output logic [CW-1:0]  res_cell_o,
    output logic [ADW-1:0] res_data_o,
    output logic [CW-1:0]  res_stop_o,
    output logic           res_half_o
);
    logic [TOT-1:0] v_q;
    logic [CW-1:0]  ix_q [TOT];

    for (genvar s = 0; s < TOT; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) begin
                v_q[s]  <= 1'b0;
                ix_q[s] <= '0;
            end else if (s == 0) begin
                v_q[s]  <= sclk_i;
                ix_q[s] <= idx_i;
            end else begin
                v_q[s]  <= v_q[s-1];
                ix_q[s] <= ix_q[s-1];
            end
        end
    end

    assign strobe_o = v_q[STROBE_LAT-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid_o <= 1'b0;
            res_idx_o   <= '0;
            res_cell_o  <= '0;
            res_data_o  <= '0;
            res_stop_o  <= '0;
            res_half_o  <= 1'b0;
        end else begin
            res_valid_o <= v_q[TOT-1];
            if (v_q[TOT-1]) begin
                res_idx_o  <= ix_q[TOT-1];
                res_cell_o <= stop_i + ix_q[TOT-1];
                res_data_o <= adc_data_i;
                res_stop_o <= stop_i;
                res_half_o <= half_i;
            end
        end
    end

    // checker: shift clocks not yet matched by a strobe, and last index out
    logic [7:0]    outst_q;
    logic [CW-1:0] last_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            outst_q <= '0;
            last_q  <= '0;
        end else begin
            outst_q <= outst_q + {7'd0, sclk_i} - {7'd0, strobe_o};
            if (res_valid_o) last_q <= res_idx_o;
        end
    end

    a_r6_strobe_after_sclk: assert property (@(posedge clk) disable iff (rst)
        strobe_o |-> (outst_q != '0));

    a_r7_idx_in_range: assert property (@(posedge clk) disable iff (rst)
        res_valid_o |-> ({1'b0, res_idx_o} < len_i));

    a_r7_idx_in_order: assert property (@(posedge clk) disable iff (rst)
        (res_valid_o && res_idx_o != '0) |-> (res_idx_o == last_q + 1'b1));

endmodule

// File: rtl/sca_readout_seq.sv
module sca_readout_seq
    import sca_pkg::*;
#(
    parameter int CELLS      = 1024,
    parameter int SETW       = 8,
    parameter int ADW        = 12,
    parameter int STROBE_LAT = 2,
    parameter int DATA_LAT   = 1,
    localparam int CW        = $clog2(CELLS),
    localparam int LW        = CW + 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cfg_cascade,
    input  logic            cfg_segment,
    input  logic            cfg_roi_en,
    input  logic [LW-1:0]   cfg_roi_len,
    input  logic [SETW-1:0] cfg_settle,
    input  logic            trig,
    input  logic [CW-1:0]   smp_pos,
    input  logic            smp_srout,
    input  logic [ADW-1:0]  adc_data,
    output logic            smp_wen,
    output logic            smp_load,
    output logic            smp_sclk,
    output logic [3:0]      smp_addr,
    output logic            cfg_sclk,
    output logic            cfg_sdata,
    output logic [1:0]      cfg_sel,
    output logic            adc_strobe,
    output logic            busy,
    output logic            done,
    output logic            mode_err,
    output logic            res_valid,
    output logic [CW-1:0]   res_idx,
    output logic [CW-1:0]   res_cell,
    output logic [ADW-1:0]  res_data,
    output logic [CW-1:0]   res_stop,
    output logic            res_half
);
    logic          ld_busy;
    logic          casc;
    logic [CW-1:0] idx;
    logic [CW-1:0] stop;
    logic          half;
    logic [LW-1:0] len;

    sca_cfg_loader u_loader (
        .clk      (clk),
        .rst      (rst),
        .cascade_i(cfg_cascade),
        .busy_o   (ld_busy),
        .casc_o   (casc),
        .sclk_o   (cfg_sclk),
        .sdata_o  (cfg_sdata),
        .sel_o    (cfg_sel)
    );

    sca_seq_fsm #(
        .CELLS(CELLS),
        .SETW (SETW),
        .TOT  (STROBE_LAT + DATA_LAT)
    ) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .ld_busy_i(ld_busy),
        .casc_i   (casc),
        .seg_i    (cfg_segment),
        .roi_en_i (cfg_roi_en),
        .roi_len_i(cfg_roi_len),
        .settle_i (cfg_settle),
        .trig_i   (trig),
        .pos_i    (smp_pos),
        .srout_i  (smp_srout),
        .wen_o    (smp_wen),
        .load_o   (smp_load),
        .sclk_o   (smp_sclk),
        .addr_o   (smp_addr),
        .busy_o   (busy),
        .done_o   (done),
        .err_o    (mode_err),
        .idx_o    (idx),
        .stop_o   (stop),
        .half_o   (half),
        .len_o    (len)
    );

    sca_adc_pipe #(
        .CELLS     (CELLS),
        .ADW       (ADW),
        .STROBE_LAT(STROBE_LAT),
        .DATA_LAT  (DATA_LAT)
    ) u_pipe (
        .clk        (clk),
        .rst        (rst),
        .sclk_i     (smp_sclk),
        .idx_i      (idx),
        .stop_i     (stop),
        .half_i     (half),
        .len_i      (len),
        .adc_data_i (adc_data),
        .strobe_o   (adc_strobe),
        .res_valid_o(res_valid),
        .res_idx_o  (res_idx),
        .res_cell_o (res_cell),
        .res_data_o (res_data),
        .res_stop_o (res_stop),
        .res_half_o (res_half)
    );

endmodule

// File: tb/sca_readout_seq_tb.sv
`timescale 1ns/1ps
module sca_readout_seq_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_cascade = 1'b0, cfg_segment = 1'b0, cfg_roi_en = 1'b0;
    logic [10:0] cfg_roi_len = '0;
    logic [7:0]  cfg_settle = '0;
    logic        trig = 1'b0;
    logic [9:0]  smp_pos = '0;
    logic        smp_srout = 1'b0;
    logic [11:0] adc_data = '0;
    logic        smp_wen, smp_load, smp_sclk, cfg_sclk, cfg_sdata, adc_strobe;
    logic        busy, done, mode_err, res_valid, res_half;
    logic [3:0]  smp_addr;
    logic [1:0]  cfg_sel;
    logic [9:0]  res_idx, res_cell, res_stop;
    logic [11:0] res_data;

    sca_readout_seq u_dut (
        .clk(clk), .rst(rst), .cfg_cascade(cfg_cascade), .cfg_segment(cfg_segment),
        .cfg_roi_en(cfg_roi_en), .cfg_roi_len(cfg_roi_len), .cfg_settle(cfg_settle),
        .trig(trig), .smp_pos(smp_pos), .smp_srout(smp_srout), .adc_data(adc_data),
        .smp_wen(smp_wen), .smp_load(smp_load), .smp_sclk(smp_sclk), .smp_addr(smp_addr),
        .cfg_sclk(cfg_sclk), .cfg_sdata(cfg_sdata), .cfg_sel(cfg_sel),
        .adc_strobe(adc_strobe), .busy(busy), .done(done), .mode_err(mode_err),
        .res_valid(res_valid), .res_idx(res_idx), .res_cell(res_cell),
        .res_data(res_data), .res_stop(res_stop), .res_half(res_half)
    );

    always #10 clk = ~clk;

    int n_chk = 0, n_bad = 0, cyc = 0;
    bit finished = 0;

    always @(posedge clk) cyc++;

    // monitor records
    int cfg_n, sel_bad, load_n, load_cyc, wen_fall, wen_rise, addr_n, busy_n;
    int sclk_n, strobe_n, res_n, done_n, done_cyc, trig_cyc;
    int sclk_cyc [2048];
    int strobe_cyc [2048];
    int r_cyc [2048];
    int r_idx [2048];
    int r_cell [2048];
    int r_data [2048];
    int r_stop, r_half;
    logic [23:0] cfg_word;
    logic wen_prev = 1'b0;

    always @(negedge clk) begin
        if (cfg_sclk) begin
            if (cfg_n < 24) begin
                cfg_word[23-cfg_n] = cfg_sdata;
                if (int'(cfg_sel) != cfg_n / 8) sel_bad++;
            end
            cfg_n++;
        end
        if (smp_load) begin load_n++; load_cyc = cyc; end
        if (wen_prev && !smp_wen) wen_fall = cyc;
        if (!wen_prev && smp_wen) wen_rise = cyc;
        wen_prev = smp_wen;
        if (smp_addr == 4'b1101) addr_n++;
        if (busy) busy_n++;
        if (smp_sclk) begin
            if (sclk_n < 2048) sclk_cyc[sclk_n] = cyc;
            sclk_n++;
        end
        if (adc_strobe) begin
            if (strobe_n < 2048) strobe_cyc[strobe_n] = cyc;
            adc_data = 12'h100 + 12'(strobe_n);
            strobe_n++;
        end
        if (res_valid) begin
            if (res_n < 2048) begin
                r_cyc[res_n] = cyc; r_idx[res_n] = int'(res_idx);
                r_cell[res_n] = int'(res_cell); r_data[res_n] = int'(res_data);
            end
            r_stop = int'(res_stop); r_half = int'(res_half);
            res_n++;
        end
        if (done) begin done_n++; done_cyc = cyc; end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_mon();
        cfg_n = 0; sel_bad = 0; load_n = 0; load_cyc = -1; wen_fall = -1; wen_rise = -1;
        addr_n = 0; busy_n = 0; sclk_n = 0; strobe_n = 0; res_n = 0; done_n = 0;
        done_cyc = -1; r_stop = -1; r_half = -1;
    endtask

    task automatic do_reset(input logic casc);
        @(posedge clk); #2;
        rst = 1'b1; cfg_cascade = casc;
        repeat (3) @(posedge clk);
        #2; clear_mon();
        @(negedge clk);
        chk(!smp_wen && !busy && !res_valid && !done, "R1 reset outputs idle", int'(smp_wen), 0);
        @(posedge clk); #2; rst = 1'b0;
        @(negedge clk);
        chk(!smp_wen, "R1 wen low while presetting", int'(smp_wen), 0);
        repeat (60) @(posedge clk);
        @(negedge clk);
        chk(cfg_n == 24, "R1 preset bit count", cfg_n, 24);
        chk(cfg_word == {8'h01, (casc ? 8'h55 : 8'hFF), 8'hFF}, "R1 preset contents",
            int'(cfg_word), int'({8'h01, (casc ? 8'h55 : 8'hFF), 8'hFF}));
        chk(sel_bad == 0, "R1 preset select order", sel_bad, 0);
        chk(smp_wen && !busy, "R1 sampling after preset", int'(smp_wen), 1);
    endtask

    task automatic fire(input int pos, input int settle, input logic roi_en,
                        input int roi_len, input logic srout);
        @(posedge clk); #2;
        clear_mon();
        smp_pos = 10'(pos); cfg_settle = 8'(settle); cfg_roi_en = roi_en;
        cfg_roi_len = 11'(roi_len); smp_srout = srout;
        trig = 1'b1; trig_cyc = cyc;
        @(posedge clk); #2; trig = 1'b0;
    endtask

    task automatic wait_done();
        while (done_n == 0) @(posedge clk);
        repeat (3) @(posedge clk);
    endtask

    task automatic check_event(input string tag, input int pos, input int settle,
                               input int n, input logic casc, input logic srout);
        int bad;
        chk(load_n == 1, {tag, " R2 one load pulse"}, load_n, 1);
        chk(wen_fall == trig_cyc + 1, {tag, " R2 wen drops after trigger"}, wen_fall, trig_cyc + 1);
        chk(load_cyc == trig_cyc + (casc ? 3 : 1), {tag, " R2 R3 load cycle"}, load_cyc,
            trig_cyc + (casc ? 3 : 1));
        chk(addr_n == (casc ? 2 : 0), {tag, " R3 status address cycles"}, addr_n, casc ? 2 : 0);
        chk(r_half == (casc ? int'(srout) : 0), {tag, " R3 half bit"}, r_half, casc ? int'(srout) : 0);
        chk(sclk_cyc[0] - load_cyc == settle + 1, {tag, " R4 settle gap"},
            sclk_cyc[0] - load_cyc, settle + 1);
        chk(sclk_n == n, {tag, " R5 shift count"}, sclk_n, n);
        bad = 0;
        for (int k = 1; k < n; k++) if (sclk_cyc[k] - sclk_cyc[k-1] != 2) bad++;
        chk(bad == 0, {tag, " R5 shift spacing"}, bad, 0);
        bad = 0;
        for (int k = 0; k < n; k++) begin
            if (strobe_cyc[k] - sclk_cyc[k] != 2) bad++;
            if (r_cyc[k] - strobe_cyc[k] != 2) bad++;
        end
        chk(bad == 0 && strobe_n == n, {tag, " R6 strobe and result timing"}, bad, 0);
        bad = 0;
        for (int k = 0; k < n; k++) if (r_data[k] != 12'h100 + k) bad++;
        chk(bad == 0, {tag, " R6 captured data"}, bad, 0);
        bad = 0;
        for (int k = 0; k < n; k++)
            if (r_idx[k] != k || r_cell[k] != (pos + k) % 1024) bad++;
        chk(bad == 0 && res_n == n, {tag, " R7 index and cell"}, bad + res_n, n);
        chk(r_stop == pos, {tag, " R7 stop cell"}, r_stop, pos);
        chk(done_n == 1 && done_cyc == r_cyc[n-1] + 1, {tag, " R8 done after last result"},
            done_cyc, r_cyc[n-1] + 1);
        chk(busy_n == done_cyc - trig_cyc - 1, {tag, " R8 busy span"}, busy_n,
            done_cyc - trig_cyc - 1);
        chk(wen_rise == done_cyc + 1, {tag, " R8 sampling resumes"}, wen_rise, done_cyc + 1);
    endtask

    task automatic t_full_wrap();
        fire(1000, 10, 1'b0, 0, 1'b0); wait_done();
        check_event("full", 1000, 10, 1024, 1'b0, 1'b0);
    endtask

    task automatic t_roi_short();
        fire(5, 0, 1'b1, 128, 1'b0); wait_done();
        check_event("roi128", 5, 0, 128, 1'b0, 1'b0);
        fire(1023, 1, 1'b1, 1, 1'b0); wait_done();
        check_event("roi1", 1023, 1, 1, 1'b0, 1'b0);
    endtask

    task automatic t_roi_zero();
        fire(0, 3, 1'b1, 0, 1'b0); wait_done();
        check_event("roi0", 0, 3, 1024, 1'b0, 1'b0);
    endtask

    task automatic t_busy_trigger();
        fire(300, 2, 1'b1, 256, 1'b0);
        repeat (100) @(posedge clk);
        #2; smp_pos = 10'd77; trig = 1'b1;
        @(posedge clk); #2; trig = 1'b0;
        wait_done();
        repeat (20) @(posedge clk);
        @(negedge clk);
        chk(load_n == 1, "R9 no second load", load_n, 1);
        chk(r_stop == 300, "R9 stop cell kept", r_stop, 300);
        chk(res_n == 256 && done_n == 1, "R9 single event", res_n, 256);
    endtask

    task automatic t_segment();
        @(posedge clk); #2; cfg_segment = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk(mode_err, "R10 segmented request flagged", int'(mode_err), 1);
        fire(40, 0, 1'b0, 0, 1'b0);
        repeat (30) @(posedge clk);
        @(negedge clk);
        chk(load_n == 0 && !busy, "R10 trigger ignored", load_n, 0);
        chk(smp_wen, "R10 sampling continues", int'(smp_wen), 1);
        @(posedge clk); #2; cfg_segment = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk(!mode_err, "R10 flag clears", int'(mode_err), 0);
    endtask

    task automatic t_cascade();
        do_reset(1'b1);
        fire(512, 5, 1'b1, 64, 1'b1); wait_done();
        check_event("casc1", 512, 5, 64, 1'b1, 1'b1);
        fire(1010, 0, 1'b1, 16, 1'b0); wait_done();
        check_event("casc0", 1010, 0, 16, 1'b1, 1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        clear_mon();
        do_reset(1'b0);
        t_full_wrap();
        t_roi_short();
        t_roi_zero();
        t_busy_trigger();
        t_segment();
        t_cascade();
        finished = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule